// File: doc/BRIEF.md
# I2C Slave Address-Match Status Tracker

This block listens to an I2C bus from the slave side. It never drives the bus. SCL and SDA are brought into the local clock domain. The block detects start, repeated-start and stop conditions, and it collects the first byte after every start. That byte is checked against a bank of programmable 7-bit slave IDs and against the general-call address. The block keeps a 16-bit read-only status word that tells firmware four things: whether the slave was addressed, which ID matched, whether a repeated start occurred, and which general-call sub-command arrived.

A stop that ends an addressed transfer sets a sticky flag, which drives an interrupt output when the stop-interrupt enable is set. A one-cycle read strobe clears that flag. A separate one-cycle strobe clears the general-call code field.

A small state machine orders the bus phases:
- **ST_IDLE**: no transfer.
- **ST_ADDR**: collecting the address byte.
- **ST_GCCMD**: collecting the byte after a general-call address.
- **ST_ACTIVE**: addressed, waiting for the end of the transfer.
- **ST_IGNORE**: not addressed, waiting for the next condition.

The transitions are:
- Any state goes to ST_ADDR on a start.
- Any state goes to ST_IDLE on a stop, or while the slave is disabled.
- ST_ADDR goes to ST_GCCMD on a general-call address.
- ST_ADDR goes to ST_ACTIVE on an ID hit.
- ST_ADDR goes to ST_IGNORE on the start byte or on a miss.
- ST_GCCMD goes to ST_ACTIVE when its byte is complete.

Top module: `i2c_slv_addr_tracker`

## Requirements
- R1: After reset the status word is 0x0000 and the interrupt output is low. The status bits are:
  - bit 14: busy
  - bit 13: repeated start
  - bits 12:11: match index
  - bit 10: stop detected
  - bits 9:8: general-call code
  - bits 15 and 7:0: always read 0
- R2: A start is SDA falling while SCL is high. Bits are sampled on SCL rising edges, MSB first, and the ninth clock (acknowledge) is skipped. Address bits are byte bits 7:1, and bit 0 is read/write. An address equal to a programmed ID sets busy (bit 14). An address that matches nothing leaves busy at 0. Address 0 never matches an ID.
- R3: On a hit, bits 12:11 take the index of the matching ID (00 to 11 for ID0 to ID3). When several IDs are equal, the lowest index wins. The field holds its value until the next hit.
- R4: A stop is SDA rising while SCL is high. A stop that follows an addressed transfer (ID hit or general call) sets bit 10. The interrupt output equals bit 10 AND the stop-interrupt enable. A read-strobe pulse clears bit 10. If a read strobe and a stop arrive in the same cycle, the stop's set wins. A stop after an unaddressed transfer leaves bit 10 unchanged.
- R5: The start byte 0x01 sets busy but does not count as addressed, so the stop that follows does not set bit 10.
- R6: A start that arrives while busy is 1 sets bit 13. A stop clears both bit 14 and bit 13.
- R7: With general-call enable set, the address byte 0x00 sets busy. The next byte sets bits 9:8:
  - 0x06 sets 01 (reset and program).
  - 0x04 sets 10 (program only).
  - A byte whose bits 7:1 equal the last ID (ID3) sets 11 (alternative ID).
  - Any other byte leaves the field unchanged.
- R8: With general-call enable clear, the address byte 0x00 is ignored: busy stays 0 and bits 9:8 stay unchanged.
- R9: Bits 9:8 are sticky. Stops and later general-call reset commands do not clear them. Only a pulse on the clear strobe does, and the clear wins over a same-cycle set.
- R10: While slave-enable is 0:
  - Busy and repeated start are forced to 0.
  - Bits 12:8 hold their values.
  - The read and clear strobes and all bus activity have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line, asynchronous |
| slv_en | input | 1 | Slave tracking enable |
| gc_en | input | 1 | General-call recognition enable |
| stop_irq_en | input | 1 | Interrupt enable for the stop-detected flag |
| slave_ids | input | NUM_ID*7 | Programmable 7-bit IDs, packed with ID0 in the lowest slice |
| status_rd | input | 1 | One-cycle strobe for a status read; clears bit 10 |
| gc_id_clr | input | 1 | One-cycle strobe that clears bits 9:8 |
| status_o | output | 16 | Status word |
| irq_o | output | 1 | Stop-after-address interrupt |

## Verification
The bench builds the block with its default parameters:
- four IDs
- a two-stage line synchronizer
- eight-bit bytes

These values give the full two-bit match field and an alternative ID at index 3, so every match code, the lowest-index priority case and all three general-call codes can each be driven with real bus waveforms. The bus timing is slow enough that the synchronizer and edge-detect delay settle well inside each bus phase.

// File: rtl/i2c_trk_pkg.sv
package i2c_trk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_GCCMD,
        ST_ACTIVE,
        ST_IGNORE
    } trk_state_e;

    typedef enum logic [1:0] {
        GC_NONE     = 2'b00,
        GC_RST_PROG = 2'b01,
        GC_PROG     = 2'b10,
        GC_ALT      = 2'b11
    } gc_code_e;

    localparam logic [7:0] START_BYTE   = 8'h01;
    localparam logic [7:0] GC_ADDR_BYTE = 8'h00;
    localparam logic [7:0] GC_CMD_RST   = 8'h06;
    localparam logic [7:0] GC_CMD_PROG  = 8'h04;

    localparam int STS_BUSY = 14;
    localparam int STS_REP  = 13;
    localparam int STS_MID  = 11;
    localparam int STS_STOP = 10;
    localparam int STS_GC   = 8;

endpackage

// File: rtl/i2c_trk_sync.sv
module i2c_trk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic start_o,
    output logic stop_o,
    output logic scl_rise_o,
    output logic sda_o
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] line_raw;
    logic [NLINES-1:0] line_now;
    logic [NLINES-1:0] line_prev;

    assign line_raw = {sda_in, scl_in};

    genvar g;
    generate
        for (g = 0; g < NLINES; g++) begin : g_line
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain        <= '1;
                    line_prev[g] <= 1'b1;
                end else begin
                    chain        <= {chain[STAGES-2:0], line_raw[g]};
                    line_prev[g] <= chain[STAGES-1];
                end
            end
            assign line_now[g] = chain[STAGES-1];
        end
    endgenerate

    always_comb begin
        start_o    = line_now[0] && line_prev[0] && line_prev[1] && !line_now[1];
        stop_o     = line_now[0] && line_prev[0] && !line_prev[1] && line_now[1];
        scl_rise_o = line_now[0] && !line_prev[0];
        sda_o      = line_now[1];
    end

endmodule

// File: rtl/i2c_trk_shift.sv
module i2c_trk_shift #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            scl_rise,
    input  logic            sda,
    output logic            byte_vld,
    output logic [BITS-1:0] byte_o
);
    localparam int CNT_W = $clog2(BITS + 1);

    logic [CNT_W-1:0] cnt;
    logic [BITS-2:0]  shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            shreg <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (scl_rise) begin
            if (cnt == CNT_W'(BITS)) begin
                cnt <= '0;
            end else begin
                shreg <= {shreg[BITS-3:0], sda};
                cnt   <= cnt + 1'b1;
            end
        end
    end

    assign byte_vld = scl_rise && !clr && (cnt == CNT_W'(BITS - 1));
    assign byte_o   = {shreg, sda};

endmodule

// File: rtl/i2c_trk_match.sv
module i2c_trk_match #(
    parameter int NUM_ID = 4,
    parameter int ADDR_W = 7,
    localparam int IDX_W = $clog2(NUM_ID)
) (
    input  logic [ADDR_W-1:0]             addr,
    input  logic [NUM_ID-1:0][ADDR_W-1:0] ids,
    output logic                          hit,
    output logic [IDX_W-1:0]              idx
);
    logic [NUM_ID-1:0] hits;

    genvar g;
    generate
        for (g = 0; g < NUM_ID; g++) begin : g_cmp
            assign hits[g] = (ids[g] == addr);
        end
    endgenerate

    always_comb begin
        idx = '0;
        for (int k = NUM_ID - 1; k >= 0; k--) begin
            if (hits[k]) idx = IDX_W'(k);
        end
        hit = (|hits) && (addr != '0);
    end

endmodule

// File: rtl/i2c_slv_addr_tracker.sv
module i2c_slv_addr_tracker
    import i2c_trk_pkg::*;
#(
    parameter int NUM_ID      = 4,
    parameter int ADDR_W      = 7,
    parameter int SYNC_STAGES = 2,
    localparam int BYTE_W     = ADDR_W + 1,
    localparam int IDX_W      = $clog2(NUM_ID)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          scl_in,
    input  logic                          sda_in,
    input  logic                          slv_en,
    input  logic                          gc_en,
    input  logic                          stop_irq_en,
    input  logic [NUM_ID-1:0][ADDR_W-1:0] slave_ids,
    input  logic                          status_rd,
    input  logic                          gc_id_clr,
    output logic [15:0]                   status_o,
    output logic                          irq_o
);
    logic              ev_start, ev_stop, scl_rise, sda_s;
    logic              byte_vld;
    logic [BYTE_W-1:0] rx_byte;
    logic              id_hit;
    logic [IDX_W-1:0]  id_idx;

    trk_state_e        state_q, state_d;
    logic              busy_q, rep_q, stop_q, addressed_q;
    logic [IDX_W-1:0]  mid_q;
    gc_code_e          gc_q, gc_new;

    i2c_trk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_in     (scl_in),
        .sda_in     (sda_in),
        .start_o    (ev_start),
        .stop_o     (ev_stop),
        .scl_rise_o (scl_rise),
        .sda_o      (sda_s)
    );

    i2c_trk_shift #(.BITS(BYTE_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (ev_start | ev_stop),
        .scl_rise (scl_rise),
        .sda      (sda_s),
        .byte_vld (byte_vld),
        .byte_o   (rx_byte)
    );

    i2c_trk_match #(.NUM_ID(NUM_ID), .ADDR_W(ADDR_W)) u_match (
        .addr (rx_byte[BYTE_W-1:1]),
        .ids  (slave_ids),
        .hit  (id_hit),
        .idx  (id_idx)
    );

    // next-state decode
    always_comb begin
        state_d = state_q;
        if (!slv_en) begin
            state_d = ST_IDLE;
        end else if (ev_start) begin
            state_d = ST_ADDR;
        end else if (ev_stop) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_ADDR: begin
                    if (byte_vld) begin
                        if (rx_byte == START_BYTE)                state_d = ST_IGNORE;
                        else if (rx_byte == GC_ADDR_BYTE && gc_en) state_d = ST_GCCMD;
                        else if (id_hit)                           state_d = ST_ACTIVE;
                        else                                       state_d = ST_IGNORE;
                    end
                end
                ST_GCCMD: if (byte_vld) state_d = ST_ACTIVE;
                default: ;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // general-call sub-command decode
    always_comb begin
        gc_new = GC_NONE;
        if (rx_byte == GC_CMD_RST)                             gc_new = GC_RST_PROG;
        else if (rx_byte == GC_CMD_PROG)                       gc_new = GC_PROG;
        else if (rx_byte[BYTE_W-1:1] == slave_ids[NUM_ID-1])   gc_new = GC_ALT;
    end

    // status outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q      <= 1'b0;
            rep_q       <= 1'b0;
            stop_q      <= 1'b0;
            addressed_q <= 1'b0;
            mid_q       <= '0;
            gc_q        <= GC_NONE;
        end else if (!slv_en) begin
            busy_q      <= 1'b0;
            rep_q       <= 1'b0;
            addressed_q <= 1'b0;
        end else begin
            if (ev_start && busy_q) rep_q <= 1'b1;
            if (ev_stop) begin
                busy_q      <= 1'b0;
                rep_q       <= 1'b0;
                addressed_q <= 1'b0;
                if (addressed_q)    stop_q <= 1'b1;
                else if (status_rd) stop_q <= 1'b0;
            end else if (status_rd) begin
                stop_q <= 1'b0;
            end
            if (state_q == ST_ADDR && byte_vld) begin
                if (rx_byte == START_BYTE) begin
                    busy_q <= 1'b1;
                end else if (rx_byte == GC_ADDR_BYTE && gc_en) begin
                    busy_q      <= 1'b1;
                    addressed_q <= 1'b1;
                end else if (id_hit) begin
                    busy_q      <= 1'b1;
                    addressed_q <= 1'b1;
                    mid_q       <= id_idx;
                end
            end
            if (gc_id_clr) begin
                gc_q <= GC_NONE;
            end else if (state_q == ST_GCCMD && byte_vld && gc_new != GC_NONE) begin
                gc_q <= gc_new;
            end
        end
    end

    always_comb begin
        status_o                    = '0;
        status_o[STS_BUSY]          = busy_q;
        status_o[STS_REP]           = rep_q;
        status_o[STS_MID +: 2]      = 2'(mid_q);
        status_o[STS_STOP]          = stop_q;
        status_o[STS_GC +: 2]       = gc_q;
        irq_o                       = stop_q && stop_irq_en;
    end

endmodule

// File: rtl/i2c_trk_chk.sv
module i2c_trk_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        slv_en,
    input logic        status_rd,
    input logic        gc_id_clr,
    input logic [15:0] status_o
);
    AST_REP_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[13] |-> status_o[14]); // R6

    AST_STOP_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[10]) |-> $fell(status_o[14])); // R4

    AST_READ_CLEARS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && slv_en && !status_o[14]) |=> !status_o[10]); // R4

    AST_GC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[9:8] != 2'b00 && !gc_id_clr) |=> (status_o[9:8] != 2'b00)); // R9

    AST_DISABLE_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !slv_en |=> (!status_o[14] && !status_o[13])); // R10

    AST_DISABLE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        !slv_en |=> $stable(status_o[12:8])); // R10

    AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[15] == 1'b0 && status_o[7:0] == 8'h00)); // R1

endmodule

bind i2c_slv_addr_tracker i2c_trk_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .slv_en    (slv_en),
    .status_rd (status_rd),
    .gc_id_clr (gc_id_clr),
    .status_o  (status_o)
);

// File: tb/i2c_slv_addr_tracker_tb.sv
module i2c_slv_addr_tracker_tb;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             scl_in = 1'b1, sda_in = 1'b1;
    logic             slv_en = 1'b0, gc_en = 1'b0, stop_irq_en = 1'b0;
    logic [3:0][6:0]  slave_ids;
    logic             status_rd = 1'b0, gc_id_clr = 1'b0;
    logic [15:0]      status_o;
    logic             irq_o;
    int               n_chk = 0, n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_slv_addr_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .slv_en(slv_en), .gc_en(gc_en), .stop_irq_en(stop_irq_en),
        .slave_ids(slave_ids), .status_rd(status_rd), .gc_id_clr(gc_id_clr),
        .status_o(status_o), .irq_o(irq_o)
    );

    function automatic logic [15:0] mk(input logic b, input logic r, input logic [1:0] m,
                                       input logic s, input logic [1:0] g);
        return {1'b0, b, r, m, s, g, 8'h00};
    endfunction

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic chk_sts(input string req, input logic [15:0] exp);
        n_chk++;
        if (status_o !== exp) begin
            n_bad++;
            $display("FAIL %s status actual=%h expected=%h", req, status_o, exp);
        end
    endtask

    task automatic chk_irq(input string req, input logic exp);
        n_chk++;
        if (irq_o !== exp) begin
            n_bad++;
            $display("FAIL %s irq actual=%b expected=%b", req, irq_o, exp);
        end
    endtask

    task automatic bus_start();
        sda_in = 1'b1; tick(Q); scl_in = 1'b1; tick(Q);
        sda_in = 1'b0; tick(Q); scl_in = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_in = 1'b0; tick(Q); scl_in = 1'b1; tick(Q); sda_in = 1'b1; tick(Q);
    endtask

    task automatic send_bit(input logic b);
        sda_in = b; tick(Q); scl_in = 1'b1; tick(Q); scl_in = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        send_bit(1'b1);
    endtask

    task automatic pulse_rd();
        status_rd = 1'b1; tick(1); status_rd = 1'b0; tick(2);
    endtask

    task automatic pulse_clr();
        gc_id_clr = 1'b1; tick(1); gc_id_clr = 1'b0; tick(2);
    endtask

    task automatic t_reset();
        chk_sts("R1", 16'h0000);
        chk_irq("R1", 1'b0);
    endtask

    task automatic t_match();
        bus_start(); send_byte({7'h56, 1'b0});
        chk_sts("R2 R3", mk(1, 0, 2'd2, 0, 2'd0));
        bus_stop();
        chk_sts("R4", mk(0, 0, 2'd2, 1, 2'd0));
        chk_irq("R4", 1'b1);
        pulse_rd();
        chk_sts("R4 rd", mk(0, 0, 2'd2, 0, 2'd0));
        chk_irq("R4 rd", 1'b0);
    endtask

    task automatic t_miss();
        bus_start(); send_byte({7'h11, 1'b1});
        chk_sts("R2 miss", mk(0, 0, 2'd2, 0, 2'd0));
        bus_stop();
        chk_sts("R4 unaddressed", mk(0, 0, 2'd2, 0, 2'd0));
    endtask

    task automatic t_priority();
        slave_ids[1] = 7'h56;
        bus_start(); send_byte({7'h56, 1'b0});
        chk_sts("R3 priority", mk(1, 0, 2'd1, 0, 2'd0));
        bus_stop(); pulse_rd();
        slave_ids[1] = 7'h34;
    endtask

    task automatic t_repstart();
        bus_start(); send_byte({7'h12, 1'b0});
        chk_sts("R3 id0", mk(1, 0, 2'd0, 0, 2'd0));
        bus_start();
        chk_sts("R6 rep", mk(1, 1, 2'd0, 0, 2'd0));
        send_byte({7'h78, 1'b1});
        chk_sts("R3 id3", mk(1, 1, 2'd3, 0, 2'd0));
        bus_stop();
        chk_sts("R6 stop", mk(0, 0, 2'd3, 1, 2'd0));
        pulse_rd();
    endtask

    task automatic t_startbyte();
        bus_start(); send_byte(8'h01);
        chk_sts("R5 busy", mk(1, 0, 2'd3, 0, 2'd0));
        bus_stop();
        chk_sts("R5 nostop", mk(0, 0, 2'd3, 0, 2'd0));
    endtask

    task automatic t_gc_off();
        gc_en = 1'b0;
        bus_start(); send_byte(8'h00); send_byte(8'h06);
        chk_sts("R8", mk(0, 0, 2'd3, 0, 2'd0));
        bus_stop();
        chk_sts("R8 stop", mk(0, 0, 2'd3, 0, 2'd0));
    endtask

    task automatic t_gc_on();
        gc_en = 1'b1;
        bus_start(); send_byte(8'h00);
        chk_sts("R7 busy", mk(1, 0, 2'd3, 0, 2'd0));
        send_byte(8'h06);
        chk_sts("R7 rst", mk(1, 0, 2'd3, 0, 2'd1));
        bus_stop();
        chk_sts("R9 sticky", mk(0, 0, 2'd3, 1, 2'd1));
        pulse_rd();
        bus_start(); send_byte(8'h00); send_byte(8'h04); bus_stop();
        chk_sts("R7 prog", mk(0, 0, 2'd3, 1, 2'd2));
        pulse_rd();
        bus_start(); send_byte(8'h00); send_byte(8'h20); bus_stop();
        chk_sts("R7 other", mk(0, 0, 2'd3, 1, 2'd2));
        pulse_rd();
        bus_start(); send_byte(8'h00); send_byte({7'h78, 1'b0}); bus_stop();
        chk_sts("R7 alt", mk(0, 0, 2'd3, 1, 2'd3));
        pulse_rd();
        pulse_clr();
        chk_sts("R9 clr", mk(0, 0, 2'd3, 0, 2'd0));
    endtask

    task automatic t_disable();
        bus_start(); send_byte(8'h00); send_byte(8'h04); bus_stop();
        bus_start(); send_byte({7'h12, 1'b0});
        chk_sts("R10 pre", mk(1, 0, 2'd0, 1, 2'd2));
        slv_en = 1'b0; tick(2);
        chk_sts("R10 off", mk(0, 0, 2'd0, 1, 2'd2));
        pulse_rd(); pulse_clr();
        bus_stop();
        bus_start(); send_byte({7'h78, 1'b0});
        chk_sts("R10 frozen", mk(0, 0, 2'd0, 1, 2'd2));
        bus_stop();
        slv_en = 1'b1; tick(2);
        pulse_rd();
        chk_sts("R10 back", mk(0, 0, 2'd0, 0, 2'd2));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        slave_ids = {7'h78, 7'h56, 7'h34, 7'h12};
        tick(4);
        rst_n = 1'b1; tick(2);
        t_reset();
        slv_en = 1'b1; stop_irq_en = 1'b1; tick(2);
        t_match();
        t_miss();
        t_priority();
        t_repstart();
        t_startbyte();
        t_gc_off();
        t_gc_on();
        t_disable();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule